// File: doc/BRIEF.md
# Retention-Binned Row Refresh Controller

This block walks every row of a memory array in a fixed ascending sweep and decides, row by row, whether that row needs a refresh command in the current sweep. Rows with weak retention are loaded into one of two compact set-membership filters. One filter holds the fastest-decaying rows and the other holds the middle class. A row that neither filter reports is refreshed at the slowest cadence. The result is that most rows see a quarter of the refresh traffic of a fixed worst-case scheme. No row that was loaded into a bin is ever refreshed less often than its bin demands.

Each filter is a bit array indexed by two XOR-fold hashes of the row address. An insert sets both indexed bits, and a probe reports a hit only when both bits are set. The filters cannot overflow. Their only error is an alias: an unloaded row can report a hit, and the row is then simply refreshed more often. A clear input empties both filters at once. Individual rows cannot be removed.

Time advances on a tick input. A row decision is taken every `TICKS_PER_SLOT` ticks, and one full sweep of all rows makes one base refresh window. Commands leave on a valid/ready port that carries the row address. While a command waits, the sweep holds still.

Top module: `rbin_refresh_ctrl`

## Requirements
- R1: After reset, `rfsh_valid` is 0, both filters are empty, the sweep points at row 0 and the window count is 0.
- R2: The sweep takes exactly one row decision per `TICKS_PER_SLOT` accepted ticks. Rows are visited in ascending order, and the window count increments (mod `LONG_DIV`, default 4) when row `2**ROW_W-1` is passed. With `tick` low, no decision is taken and no command appears.
- R3: A row that hits the short filter is refreshed in every window.
- R4: A row that misses the short filter but hits the mid filter is refreshed only in windows whose count mod `MID_DIV` (default 2) is 0.
- R5: A row that misses both filters is refreshed only in windows whose count is 0 (mod `LONG_DIV`).
- R6: Each filter has `2**IDX_W` bits. Hash 0 bit j is the XOR of all row bits i with i mod `IDX_W` = j. Hash 1 is computed the same way over the row rotated right by one, where rotated bit i = row bit (i+1) mod `ROW_W`. A probe hits only when the bits at both indices are set.
- R7: An insert (`ins_valid`=1, `ins_bin` 0 selects short and 1 selects mid) sets both hashed bits of the chosen filter. No bit is cleared except by clear-all, so an inserted row never tests absent. An unloaded row whose bits were set by other inserts is treated as present.
- R8: `clr_all` empties both filters on the next edge. It takes priority over an insert in the same cycle.
- R9: While `rfsh_valid`=1 and `rfsh_ready`=0, `rfsh_valid` and `rfsh_row` hold steady and ticks are ignored, so no row is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse advancing the sweep |
| ins_valid | input | 1 | Load `ins_row` into a bin this cycle |
| ins_bin | input | 1 | Bin select: 0 short, 1 mid |
| ins_row | input | ROW_W | Row address to load |
| clr_all | input | 1 | Empty both filters |
| rfsh_valid | output | 1 | Refresh command pending |
| rfsh_ready | input | 1 | Consumer accepts the command |
| rfsh_row | output | ROW_W | Row address to refresh |

## Verification
The bench models the sweep, both hashes and the window cadence on its own, and compares the exact ordered stream of commands over five windows. It therefore catches a design that refreshes an unloaded row in windows 1 to 3, drops a mid-bin row from window 2, or misses an aliased row whose bits were set by its neighbours. Further cases hold the output under backpressure, where a design that kept sweeping would skip rows, and issue clear together with an insert, where the wrong priority would leave a row resident.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
   typedef enum logic {
      BIN_SHORT = 1'b0,
      BIN_MID   = 1'b1
   } rbr_bin_e;
endpackage

// File: rtl/rbr_bloom_bank.sv
module rbr_bloom_bank #(
   parameter int ROW_W  = 6,
   parameter int IDX_W  = 5,
   parameter int HASHES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ins,
   input  logic [ROW_W-1:0] ins_row,
   input  logic [ROW_W-1:0] probe_row,
   output logic             hit
);
   localparam int M = 1 << IDX_W;

   initial begin : elab_chk
      if (IDX_W < 1 || IDX_W > 12) $fatal(1, "IDX_W out of range");
      if (HASHES < 1 || HASHES > ROW_W) $fatal(1, "HASHES out of range");
   end

   function automatic logic [IDX_W-1:0] fold(input logic [ROW_W-1:0] a, input int rot);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = 0; i < ROW_W; i++) r[i % IDX_W] = r[i % IDX_W] ^ a[(i + rot) % ROW_W];
      return r;
   endfunction

   logic [M-1:0]     bits_q;
   logic [IDX_W-1:0] ins_idx [HASHES];
   logic [IDX_W-1:0] prb_idx [HASHES];
   logic [M-1:0]     set_mask;

   for (genvar k = 0; k < HASHES; k++) begin : g_hash
      assign ins_idx[k] = fold(ins_row, k);
      assign prb_idx[k] = fold(probe_row, k);
   end

   always_comb begin
      set_mask = '0;
      hit      = 1'b1;
      for (int k = 0; k < HASHES; k++) begin
         set_mask[ins_idx[k]] = 1'b1;
         hit = hit & bits_q[prb_idx[k]];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   bits_q <= '0;
      else if (clr) bits_q <= '0;
      else if (ins) bits_q <= bits_q | set_mask;
   end

   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> bits_q == '0);  // R8
   AST_NO_REMOVAL: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (bits_q & $past(bits_q)) == $past(bits_q));  // R7
   for (genvar k = 0; k < HASHES; k++) begin : g_chk
      AST_INSERT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (ins && !clr) |=> bits_q[$past(ins_idx[k])]);  // R7
   end
endmodule

// File: rtl/rbr_sweep.sv
module rbr_sweep #(
   parameter int ROW_W          = 6,
   parameter int TICKS_PER_SLOT = 4,
   parameter int LONG_DIV       = 4,
   localparam int WIN_W         = $clog2(LONG_DIV)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hold,
   output logic [ROW_W-1:0] row,
   output logic [WIN_W-1:0] win,
   output logic             step
);
   initial begin : elab_chk
      if (TICKS_PER_SLOT < 1) $fatal(1, "TICKS_PER_SLOT must be >= 1");
      if (LONG_DIV < 2 || (LONG_DIV & (LONG_DIV - 1)) != 0) $fatal(1, "LONG_DIV must be a power of two >= 2");
   end

   logic live;
   assign live = tick && !hold;

   if (TICKS_PER_SLOT == 1) begin : g_direct
      assign step = live;
   end else begin : g_slot
      localparam int SLOT_W = $clog2(TICKS_PER_SLOT);
      localparam logic [SLOT_W-1:0] LAST = SLOT_W'(TICKS_PER_SLOT - 1);
      logic [SLOT_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    slot_q <= '0;
         else if (live) slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      end
      assign step = live && (slot_q == LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row <= '0;
         win <= '0;
      end else if (step) begin
         row <= row + 1'b1;
         if (row == '1) win <= win + 1'b1;
      end
   end

   AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> row == $past(row) + 1'b1);  // R2
   AST_WINDOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && row == '1) |=> win == $past(win) + 1'b1);  // R2
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(row) && $stable(win));  // R9
endmodule

// File: rtl/rbin_refresh_ctrl.sv
module rbin_refresh_ctrl #(
   parameter int ROW_W          = 6,
   parameter int IDX_W          = 5,
   parameter int HASHES         = 2,
   parameter int TICKS_PER_SLOT = 4,
   parameter int MID_DIV        = 2,
   parameter int LONG_DIV       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ins_valid,
   input  logic             ins_bin,
   input  logic [ROW_W-1:0] ins_row,
   input  logic             clr_all,
   output logic             rfsh_valid,
   input  logic             rfsh_ready,
   output logic [ROW_W-1:0] rfsh_row
);
   import rbr_pkg::*;
   localparam int WIN_W = $clog2(LONG_DIV);
   localparam logic [WIN_W-1:0] MID_MASK = WIN_W'(MID_DIV - 1);

   initial begin : elab_chk
      if (MID_DIV < 2 || (MID_DIV & (MID_DIV - 1)) != 0) $fatal(1, "MID_DIV must be a power of two >= 2");
      if (MID_DIV >= LONG_DIV) $fatal(1, "MID_DIV must be below LONG_DIV");
   end

   logic [ROW_W-1:0] cur_row;
   logic [WIN_W-1:0] cur_win;
   logic             step, hit_short, hit_mid, need;

   rbr_sweep #(.ROW_W(ROW_W), .TICKS_PER_SLOT(TICKS_PER_SLOT), .LONG_DIV(LONG_DIV)) u_sweep (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hold(rfsh_valid),
      .row(cur_row), .win(cur_win), .step(step));

   rbr_bloom_bank #(.ROW_W(ROW_W), .IDX_W(IDX_W), .HASHES(HASHES)) u_short (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .ins(ins_valid && rbr_bin_e'(ins_bin) == BIN_SHORT),
      .ins_row(ins_row), .probe_row(cur_row), .hit(hit_short));

   rbr_bloom_bank #(.ROW_W(ROW_W), .IDX_W(IDX_W), .HASHES(HASHES)) u_mid (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .ins(ins_valid && rbr_bin_e'(ins_bin) == BIN_MID),
      .ins_row(ins_row), .probe_row(cur_row), .hit(hit_mid));

   always_comb begin
      if (hit_short)    need = 1'b1;
      else if (hit_mid) need = (cur_win & MID_MASK) == '0;
      else              need = cur_win == '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rfsh_valid <= 1'b0;
         rfsh_row   <= '0;
      end else if (step) begin
         rfsh_valid <= need;
         rfsh_row   <= cur_row;
      end else if (rfsh_ready) begin
         rfsh_valid <= 1'b0;
      end
   end

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_valid && !rfsh_ready) |=> rfsh_valid && $stable(rfsh_row));  // R9
   AST_SHORT_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && hit_short) |=> rfsh_valid);  // R3
   AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !rfsh_valid) |=> !rfsh_valid);  // R2
endmodule

// File: tb/rbin_refresh_ctrl_test.sv
`timescale 1ns/1ps
module rbin_refresh_ctrl_test;
   localparam int ROW_W = 4, IDX_W = 3, TPS = 2, ROWS = 16, M = 8;

   logic clk = 0, rst_n = 0, tick = 0, ins_valid = 0, ins_bin = 0, clr_all = 0, rfsh_ready = 0;
   logic [ROW_W-1:0] ins_row = '0;
   logic rfsh_valid;
   logic [ROW_W-1:0] rfsh_row;

   int n_chk = 0, n_fail = 0;
   logic [M-1:0] mdl_s, mdl_m;
   int obs[$];

   always #2.5 clk = ~clk;

   rbin_refresh_ctrl #(.ROW_W(ROW_W), .IDX_W(IDX_W), .HASHES(2), .TICKS_PER_SLOT(TPS),
                       .MID_DIV(2), .LONG_DIV(4)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ins_valid(ins_valid), .ins_bin(ins_bin),
      .ins_row(ins_row), .clr_all(clr_all), .rfsh_valid(rfsh_valid),
      .rfsh_ready(rfsh_ready), .rfsh_row(rfsh_row));

   always @(negedge clk) if (rst_n && rfsh_valid && rfsh_ready) obs.push_back(int'(rfsh_row));

   task automatic check(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // hash indices as stated in R6
   function automatic int hidx(int r, int rot);
      int v = 0;
      for (int i = 0; i < ROW_W; i++) if ((r >> ((i + rot) % ROW_W)) & 1) v ^= (1 << (i % IDX_W));
      return v;
   endfunction

   function automatic bit present(logic [M-1:0] b, int r);
      return b[hidx(r, 0)] && b[hidx(r, 1)];
   endfunction

   task automatic edge_drive();
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      edge_drive();
      rst_n = 0; tick = 0; ins_valid = 0; clr_all = 0; rfsh_ready = 0;
      mdl_s = '0; mdl_m = '0;
      repeat (3) edge_drive();
      rst_n = 1;
      obs.delete();
   endtask

   task automatic load(int r, bit bin);
      ins_valid = 1; ins_bin = bin; ins_row = ROW_W'(r);
      edge_drive();
      ins_valid = 0;
      if (bin) begin mdl_m[hidx(r,0)] = 1; mdl_m[hidx(r,1)] = 1; end
      else     begin mdl_s[hidx(r,0)] = 1; mdl_s[hidx(r,1)] = 1; end
   endtask

   task automatic run_and_compare(string req, int nwin);
      int expq[$];
      for (int w = 0; w < nwin; w++)
         for (int r = 0; r < ROWS; r++)
            if (present(mdl_s, r) || (present(mdl_m, r) && w % 2 == 0) || w % 4 == 0)
               expq.push_back(r);
      tick = 1; rfsh_ready = 1;
      for (int c = 0; c < 4000 && obs.size() < expq.size(); c++) edge_drive();
      tick = 0;
      check(obs.size() >= expq.size(), {req, " count"}, obs.size(), expq.size());
      for (int i = 0; i < expq.size() && i < obs.size(); i++)
         check(obs[i] == expq[i], req, obs[i], expq[i]);
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check(rfsh_valid == 0, "R1 valid after reset", rfsh_valid, 0);
      rfsh_ready = 1;
      repeat (10) edge_drive();
      check(obs.size() == 0, "R2 no tick no command", obs.size(), 0);
      check(rfsh_valid == 0, "R2 idle without tick", rfsh_valid, 0);
   endtask

   task automatic t_empty();
      do_reset();
      run_and_compare("R5 empty filters cadence (R1 R2)", 5);
   endtask

   task automatic t_bins();
      do_reset();
      load(3, 0);
      load(9, 1);
      load(12, 1);
      check(present(mdl_s, 3), "R7 model short row present", 0, 1);
      run_and_compare("R3 R4 R6 R7 binned cadence", 5);
   endtask

   task automatic t_clear();
      do_reset();
      load(1, 0);
      load(6, 1);
      clr_all = 1; ins_valid = 1; ins_bin = 0; ins_row = 4'd5;
      edge_drive();
      clr_all = 0; ins_valid = 0;
      mdl_s = '0; mdl_m = '0;
      run_and_compare("R8 cleared filters", 5);
   endtask

   task automatic t_backpressure();
      do_reset();
      tick = 1; rfsh_ready = 0;
      repeat (20) edge_drive();
      #1;
      check(rfsh_valid == 1, "R9 valid held", rfsh_valid, 1);
      check(rfsh_row == 0, "R9 row held", rfsh_row, 0);
      repeat (20) edge_drive();
      #1;
      check(rfsh_row == 0 && rfsh_valid == 1, "R9 still held", rfsh_row, 0);
      run_and_compare("R9 no skipped rows", 1);
   endtask

   initial begin
      #100000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_empty();
      t_bins();
      t_clear();
      t_backpressure();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule